// File: doc/BRIEF.md
# Cache ECC Fault Injection Controller

This block is a small per-hart register bank that plants deliberate bit errors in the words a cache reads back. Software programs a flip mask, an optional delay and a control word through a simple register port. The block then decides when an injection is armed. It arms either at once, or after a loaded countdown reaches zero. On the first cache access after arming, it XORs the mask onto either the tag or the data word on its way to the ECC checker.

Each successful injection either disarms the bank (one-shot) or reloads the delay last written and arms again (persistent). Accesses are only corrupted when they target a cache bank that software has enabled in the control word. The cache, the ECC logic and error reporting are outside this block.

Top module: `ecc_inject_ctrl`

## Requirements
- R1: After reset the control, delay and mask registers all read 0, no injection fires, and tag and data pass through unchanged.
- R2: The register window decodes byte offset 0 as control, 8 as delay and 16 as mask. Any other offset reads 0. Control bits are: bit 0 enable, bit 1 persist, bit 2 delayed mode, bit 3 target select, and bits 4 and up one enable bit per cache bank. Other control bits read 0.
- R3: With enable set and delayed mode clear, the injection is armed in the cycle after the control write.
- R4: With enable and delayed mode both set, the counter decrements by one per clock while nonzero. Reading offset 8 returns the running count. No injection fires while the count is nonzero.
- R5: An armed injection stays armed through cycles with no access and fires on the first access, not at the moment of arming.
- R6: Target select 0 flips the tag using only the low tag-width bits of the mask and leaves the data unchanged. Target select 1 flips the data with the full mask and leaves the tag unchanged. A mask bit of 1 inverts its bit and 0 keeps it.
- R7: An access to a bank whose enable bit is clear is not modified, does not fire, and leaves the injection armed.
- R8: In one-shot mode (persist 0), a successful injection clears the enable bit, and later accesses pass unchanged.
- R9: In persistent mode, a successful injection reloads the counter with the last value written to offset 8 and keeps enable set, so the next flip waits for a new countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 7 | Byte offset inside the window |
| regWdata | input | 64 | Register write data |
| regRdata | output | 64 | Read data for regAddr (combinational) |
| accValid | input | 1 | A cache read access is presented this cycle |
| accBank | input | 3 | Bank index of the access |
| accTag | input | 24 | Tag word read from the cache |
| accData | input | 64 | Data word read from the cache |
| outTag | output | 24 | Tag word after optional flip |
| outData | output | 64 | Data word after optional flip |
| injectFire | output | 1 | High in the cycle a flip is applied |

## Verification
The bench targets the off-by-one edges of the countdown. It reads the running counter back and presents accesses just before and after expiry; a counter that decremented before enable or fired at count one would show up there. It idles between arming and the access, to catch a design that ties the flip to the expiry cycle. It probes one-shot clearing and persistent reload with back-to-back accesses, where a missing reload would fire twice in a row. Randomized target, bank-enable and mask settings catch a tag flip that uses upper mask bits, or a disabled bank that still gets corrupted.

// File: rtl/eccinj_pkg.sv
package eccinj_pkg;
  localparam int CtrlOfs = 0;
  localparam int DelayOfs = 8;
  localparam int MaskOfs = 16;

  localparam int BitEn   = 0;
  localparam int BitPst  = 1;
  localparam int BitDly  = 2;
  localparam int BitTgt  = 3;
  localparam int BitBank = 4;

  typedef struct packed {
    logic flipTag;
    logic flipData;
  } flipStrobe_t;
endpackage

// File: rtl/eccinj_ctrl.sv
module eccinj_ctrl
  import eccinj_pkg::*;
#(
  parameter int REG_W = 64,
  parameter int ADDR_W = 7,
  parameter int NUM_BANKS = 8,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic              accValid,
  input  logic [BANK_W-1:0] accBank,
  output flipStrobe_t       strobe,
  output logic [REG_W-1:0]  maskOut,
  output logic              injectFire
);
  logic enQ, pstQ, dlyModeQ, tgtQ;
  logic [NUM_BANKS-1:0] bankQ;
  logic [REG_W-1:0] delayQ, cntQ, maskQ;
  logic wrCtrl, wrDelay, wrMask, armed, fire;

  assign wrCtrl  = regWe && (regAddr == ADDR_W'(CtrlOfs));
  assign wrDelay = regWe && (regAddr == ADDR_W'(DelayOfs));
  assign wrMask  = regWe && (regAddr == ADDR_W'(MaskOfs));

  assign armed = enQ && (!dlyModeQ || (cntQ == '0));
  assign fire  = armed && accValid && bankQ[accBank];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ <= 1'b0;
      pstQ <= 1'b0;
      dlyModeQ <= 1'b0;
      tgtQ <= 1'b0;
      bankQ <= '0;
      delayQ <= '0;
      cntQ <= '0;
      maskQ <= '0;
    end else begin
      if (wrCtrl) begin
        enQ <= regWdata[BitEn];
        pstQ <= regWdata[BitPst];
        dlyModeQ <= regWdata[BitDly];
        tgtQ <= regWdata[BitTgt];
        bankQ <= regWdata[BitBank +: NUM_BANKS];
      end else if (fire && !pstQ) begin
        enQ <= 1'b0;
      end
      if (wrDelay) begin
        delayQ <= regWdata;
        cntQ <= regWdata;
      end else if (fire && pstQ) begin
        cntQ <= delayQ;
      end else if (enQ && dlyModeQ && (cntQ != '0)) begin
        cntQ <= cntQ - 1'b1;
      end
      if (wrMask) maskQ <= regWdata;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_W'(CtrlOfs): begin
        regRdata[BitEn] = enQ;
        regRdata[BitPst] = pstQ;
        regRdata[BitDly] = dlyModeQ;
        regRdata[BitTgt] = tgtQ;
        regRdata[BitBank +: NUM_BANKS] = bankQ;
      end
      ADDR_W'(DelayOfs): regRdata = cntQ;
      ADDR_W'(MaskOfs):  regRdata = maskQ;
      default: regRdata = '0;
    endcase
  end

  assign strobe.flipTag  = fire && !tgtQ;
  assign strobe.flipData = fire && tgtQ;
  assign maskOut = maskQ;
  assign injectFire = fire;

  assert_countdown_R4: assert property (@(posedge clk) disable iff (!rstN)
    (enQ && dlyModeQ && (cntQ != '0) && !wrDelay) |=> (cntQ == $past(cntQ) - 1'b1));
  assert_no_early_fire_R4: assert property (@(posedge clk) disable iff (!rstN)
    (enQ && dlyModeQ && (cntQ != '0)) |-> !injectFire);
  assert_bank_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !bankQ[accBank]) |-> !injectFire);
  assert_oneshot_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (injectFire && !pstQ && !wrCtrl) |=> !enQ);
  assert_persist_reload_R9: assert property (@(posedge clk) disable iff (!rstN)
    (injectFire && pstQ && !wrDelay && !wrCtrl) |=> (enQ && cntQ == $past(delayQ)));
endmodule

// File: rtl/eccinj_flip.sv
module eccinj_flip
  import eccinj_pkg::*;
#(
  parameter int REG_W = 64,
  parameter int TAG_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  flipStrobe_t      strobe,
  input  logic [REG_W-1:0] mask,
  input  logic [TAG_W-1:0] inTag,
  input  logic [REG_W-1:0] inData,
  output logic [TAG_W-1:0] outTag,
  output logic [REG_W-1:0] outData
);
  logic [TAG_W-1:0] tagMask;

  generate
    if (TAG_W <= REG_W) begin : g_tagMask
      assign tagMask = mask[TAG_W-1:0];
    end else begin : g_tagMaskWide
      assign tagMask = {{(TAG_W-REG_W){1'b0}}, mask};
    end
  endgenerate

  assign outTag  = inTag  ^ (strobe.flipTag  ? tagMask : '0);
  assign outData = inData ^ (strobe.flipData ? mask    : '0);

  assert_single_target_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.flipTag, strobe.flipData}));
  assert_data_kept_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flipTag |-> (outData == inData));
endmodule

// File: rtl/ecc_inject_ctrl.sv
module ecc_inject_ctrl
  import eccinj_pkg::*;
#(
  parameter int REG_W = 64,
  parameter int ADDR_W = 7,
  parameter int TAG_W = 24,
  parameter int NUM_BANKS = 8,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic              accValid,
  input  logic [BANK_W-1:0] accBank,
  input  logic [TAG_W-1:0]  accTag,
  input  logic [REG_W-1:0]  accData,
  output logic [TAG_W-1:0]  outTag,
  output logic [REG_W-1:0]  outData,
  output logic              injectFire
);
  flipStrobe_t strobe;
  logic [REG_W-1:0] mask;

  eccinj_ctrl #(.REG_W(REG_W), .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .accValid(accValid),
    .accBank(accBank), .strobe(strobe), .maskOut(mask), .injectFire(injectFire)
  );

  eccinj_flip #(.REG_W(REG_W), .TAG_W(TAG_W)) uFlip (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mask(mask),
    .inTag(accTag), .inData(accData), .outTag(outTag), .outData(outData)
  );
endmodule

// File: tb/tb_ecc_inject_ctrl.sv
module tb_ecc_inject_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8;
  localparam int TW = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [6:0] regAddr = '0;
  logic [63:0] regWdata = '0;
  logic [63:0] regRdata;
  logic accValid = 1'b0;
  logic [2:0] accBank = '0;
  logic [TW-1:0] accTag = '0;
  logic [63:0] accData = '0;
  logic [TW-1:0] outTag;
  logic [63:0] outData;
  logic injectFire;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_inject_ctrl dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .accValid(accValid),
    .accBank(accBank), .accTag(accTag), .accData(accData),
    .outTag(outTag), .outData(outData), .injectFire(injectFire)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ctrlWord(bit en, bit pst, bit dly, bit tgt, logic [NB-1:0] banks);
    return {52'd0, banks, tgt, dly, pst, en};
  endfunction

  function automatic logic [TW-1:0] expTag(bit fire, bit tgt, logic [63:0] m, logic [TW-1:0] t);
    return (fire && !tgt) ? (t ^ m[TW-1:0]) : t;
  endfunction

  function automatic logic [63:0] expData(bit fire, bit tgt, logic [63:0] m, logic [63:0] d);
    return (fire && tgt) ? (d ^ m) : d;
  endfunction

  task automatic wr(input logic [6:0] a, input logic [63:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [63:0] v);
    regAddr = a; #1;
    v = regRdata;
  endtask

  task automatic access(input logic [2:0] b, input logic [TW-1:0] t, input logic [63:0] d,
                        output logic f, output logic [TW-1:0] ot, output logic [63:0] od);
    @(negedge clk);
    accValid = 1'b1; accBank = b; accTag = t; accData = d;
    #1;
    f = injectFire; ot = outTag; od = outData;
    @(posedge clk); #1;
    accValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] v, od;
    logic [TW-1:0] ot;
    logic f;
    void'($urandom(32'h1234_abcd));

    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    rd(7'd0, v);  check("R1 ctrl", v, 64'd0);
    rd(7'd8, v);  check("R1 delay", v, 64'd0);
    rd(7'd16, v); check("R1 mask", v, 64'd0);
    access(3'd0, 24'h123456, 64'hdead_beef_0000_1111, f, ot, od);
    check("R1 fire", {63'd0, f}, 64'd0);
    check("R1 tag", {40'd0, ot}, {40'd0, 24'h123456});
    check("R1 data", od, 64'hdead_beef_0000_1111);

    // R2 register map and field layout
    wr(7'd16, 64'hffff_0000_aaaa_5555);
    rd(7'd16, v); check("R2 mask readback", v, 64'hffff_0000_aaaa_5555);
    wr(7'd0, 64'hffff_ffff_ffff_fff8);
    rd(7'd0, v);  check("R2 ctrl fields", v, 64'h0000_0000_0000_0ff8);
    rd(7'd24, v); check("R2 unmapped", v, 64'd0);
    rd(7'd4, v);  check("R2 misaligned", v, 64'd0);
    wr(7'd0, 64'd0);

    // R4 delayed arming and running counter; R5 fire on first access
    wr(7'd8, 64'd5);
    wr(7'd16, 64'h0000_0000_0000_00f0);
    wr(7'd0, ctrlWord(1, 0, 1, 1, 8'h01));
    rd(7'd8, v); check("R4 count start", v, 64'd5);
    access(3'd0, 24'h0, 64'h1, f, ot, od);
    check("R4 no fire while counting", {63'd0, f}, 64'd0);
    check("R4 data kept while counting", od, 64'h1);
    rd(7'd8, v); check("R4 count after one", v, 64'd4);
    idle(3);
    rd(7'd8, v); check("R4 count after four", v, 64'd1);
    access(3'd0, 24'h0, 64'h1, f, ot, od);
    check("R4 no fire at count one", {63'd0, f}, 64'd0);
    rd(7'd8, v); check("R4 count zero", v, 64'd0);
    idle(4);
    rd(7'd0, v); check("R5 still armed", v[0], 1'b1);
    access(3'd0, 24'habcdef, 64'h1, f, ot, od);
    check("R5 fire on first access", {63'd0, f}, 64'd1);
    check("R6 data flipped", od, 64'hf1);
    check("R6 tag untouched", {40'd0, ot}, {40'd0, 24'habcdef});
    // R8 one-shot
    rd(7'd0, v); check("R8 enable cleared", v[0], 1'b0);
    access(3'd0, 24'h0, 64'h1, f, ot, od);
    check("R8 no second fire", {63'd0, f}, 64'd0);
    check("R8 data unchanged", od, 64'h1);

    // R3 immediate arming, R7 bank gating, R6 tag uses low mask bits
    wr(7'd16, 64'hffff_ffff_ff00_000f);
    wr(7'd0, ctrlWord(1, 0, 0, 0, 8'h04));
    access(3'd3, 24'h0, 64'h0, f, ot, od);
    check("R7 disabled bank no fire", {63'd0, f}, 64'd0);
    check("R7 disabled bank tag", {40'd0, ot}, 64'd0);
    rd(7'd0, v); check("R7 still armed", v[0], 1'b1);
    access(3'd2, 24'h000000, 64'h0, f, ot, od);
    check("R3 immediate fire", {63'd0, f}, 64'd1);
    check("R6 tag low mask bits", {40'd0, ot}, {40'd0, 24'h00000f});
    check("R6 data untouched", od, 64'd0);

    // R9 persistent reload
    wr(7'd8, 64'd3);
    wr(7'd16, 64'h1);
    wr(7'd0, ctrlWord(1, 1, 1, 0, 8'h01));
    idle(3);
    access(3'd0, 24'h10, 64'h0, f, ot, od);
    check("R9 first persistent fire", {63'd0, f}, 64'd1);
    check("R9 tag flip", {40'd0, ot}, {40'd0, 24'h11});
    rd(7'd8, v); check("R9 counter reloaded", v, 64'd3);
    rd(7'd0, v); check("R9 enable kept", v[0], 1'b1);
    access(3'd0, 24'h10, 64'h0, f, ot, od);
    check("R9 no back-to-back fire", {63'd0, f}, 64'd0);
    idle(2);
    access(3'd0, 24'h10, 64'h0, f, ot, od);
    check("R9 second persistent fire", {63'd0, f}, 64'd1);

    // Random mix: persistent immediate mode (R3 R6 R7)
    for (int i = 0; i < 60; i++) begin
      logic [63:0] m, d;
      logic [TW-1:0] t;
      logic [NB-1:0] bk;
      logic [2:0] b;
      bit tgt, ef;
      m = {$urandom, $urandom};
      d = {$urandom, $urandom};
      t = TW'($urandom);
      bk = NB'($urandom);
      b = 3'($urandom);
      tgt = 1'($urandom);
      wr(7'd16, m);
      wr(7'd0, ctrlWord(1, 1, 0, tgt, bk));
      access(b, t, d, f, ot, od);
      ef = bk[b];
      check("R7 random fire", {63'd0, f}, {63'd0, ef});
      check("R6 random tag", {40'd0, ot}, {40'd0, expTag(ef, tgt, m, t)});
      check("R6 random data", od, expData(ef, tgt, m, d));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule